// File: doc/BRIEF.md
# Maskable Multi-Register Address Filter

This block decides whether a received frame is addressed to the local station. An upstream parser hands it the destination address of each frame as one or two bytes on a valid/ready byte stream. The block compares these bytes against four programmable station address registers. Two of those registers have per-bit don't-care masks. The block then reports the outcome with a single-cycle accept or discard pulse. Frame parsing, CRC checking and payload storage are handled elsewhere.

A configuration write port loads the address registers, the mask registers and a mode register. Bit 0 of the mode register selects between single-byte and two-byte addresses. Each frame is opened by a frame-start strobe. On that strobe the block takes a private copy of the whole configuration, so later writes only affect later frames.

Back-pressure rules:
- `addr_ready` is high only while the block is collecting the address bytes of an open frame.
- It stays low from reset until the first frame start.
- It drops in the cycle after the final address byte is taken, and stays low until the next frame start.
- A byte is taken only when `addr_valid` and `addr_ready` are both high and `frame_start` is low.

Top module: `addr_filter`

## Requirements
- R1: During and straight after reset, `match`, `reject` and `addr_ready` are all 0.
- R2: With mode bit 0 clear (single-byte mode), the frame is accepted when its one address byte matches any of address registers 0 to 3 (`cfg_sel` values 0 to 3).
- R3: A 1 in mask register 0 (`cfg_sel` 4) makes that bit of address register 0 a don't-care. Mask register 1 (`cfg_sel` 5) does the same for address register 1.
- R4: Address registers 2 and 3 have no mask and need an exact match in every mode.
- R5: With mode bit 0 set (two-byte mode, `cfg_sel` 6), the frame is accepted when either of two conditions holds. Pair 0: the first byte matches register 0 and the second byte matches register 1. Pair 1: the first byte matches register 2 and the second byte matches register 3.
- R6: In two-byte mode, masks 0 and 1 still act as don't-cares on pair 0.
- R7: The verdict appears in the cycle after the final address byte is taken. It is either a one-cycle `match` pulse or a one-cycle `reject` pulse, never both.
- R8: The mode and all registers are copied at frame start. Writes made while a frame is open do not affect that frame's verdict.
- R9: A frame start discards any partly collected address, so an aborted frame never produces a verdict. A byte presented in the same cycle as a frame start is dropped.
- R10: `addr_ready` follows the back-pressure rules above. Bytes offered while it is low are ignored and produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Opens a new frame and copies the configuration |
| addr_valid | input | 1 | Address byte offered |
| addr_data | input | 8 | Address byte |
| addr_ready | output | 1 | Block is collecting address bytes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | 0-3 address regs, 4-5 masks, 6 mode, 7 unused |
| cfg_wdata | input | 8 | Configuration write data |
| match | output | 1 | Frame accepted pulse |
| reject | output | 1 | Frame discarded pulse |

## Verification
The assertions assume that each frame begins with `frame_start`. Because of this, two verdicts can never fall in adjacent cycles, and every verdict is preceded by a byte taken one cycle earlier. They also assume all inputs hold known values from the first clock after reset. The stimulus meets these assumptions: it drives every input away from the clock edge, and it opens every frame with an explicit frame-start strobe. The only bytes it offers while `addr_ready` is low are the ones that deliberately probe R9 and R10.

// File: rtl/af_pkg.sv
package af_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_ADDR   = 4;
  localparam int NUM_MASKED = 2;
  localparam int NUM_PAIRS  = NUM_ADDR / 2;
  localparam int NUM_CFG    = NUM_ADDR + NUM_MASKED + 1;
  localparam int SEL_W      = $clog2(NUM_CFG);
  localparam int MODE_SEL   = NUM_ADDR + NUM_MASKED;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic                         wide;
    logic [NUM_ADDR-1:0][BYTE_W-1:0]   addr;
    logic [NUM_MASKED-1:0][BYTE_W-1:0] mask;
  } filt_cfg_t;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_OPEN = 2'd1,
    CAP_SHUT = 2'd2
  } cap_state_e;
endpackage

// File: rtl/af_cfg_bank.sv
module af_cfg_bank
  import af_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  byte_t            wdata,
  input  logic             frame_start,
  output filt_cfg_t        frame_cfg
);
  byte_t     addr_r [NUM_ADDR];
  byte_t     mask_r [NUM_MASKED];
  logic      wide_r;
  filt_cfg_t live;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n)                          addr_r[i] <= '0;
      else if (we && sel == SEL_W'(i))     addr_r[i] <= wdata;
    end
    assign live.addr[i] = addr_r[i];
  end

  for (genvar j = 0; j < NUM_MASKED; j++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)                                  mask_r[j] <= '0;
      else if (we && sel == SEL_W'(NUM_ADDR + j))  mask_r[j] <= wdata;
    end
    assign live.mask[j] = mask_r[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            wide_r <= 1'b0;
    else if (we && sel == SEL_W'(MODE_SEL)) wide_r <= wdata[0];
  end
  assign live.wide = wide_r;

  // Per-frame copy: only a frame start may change it
  always_ff @(posedge clk) begin
    if (!rst_n)           frame_cfg <= '0;
    else if (frame_start) frame_cfg <= live;
  end

  AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(frame_cfg)); // R8
endmodule

// File: rtl/af_capture.sv
module af_capture
  import af_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  logic  wide,
  input  logic  beat_valid,
  input  byte_t beat_data,
  output logic  beat_ready,
  output logic  final_beat,
  output byte_t first_byte
);
  cap_state_e state;
  logic       have_first;
  logic       take;

  assign beat_ready = (state == CAP_OPEN);
  assign take       = beat_valid && beat_ready && !frame_start;
  assign final_beat = take && (!wide || have_first);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= CAP_IDLE;
      have_first <= 1'b0;
      first_byte <= '0;
    end else if (frame_start) begin
      state      <= CAP_OPEN;
      have_first <= 1'b0;
    end else if (final_beat) begin
      state      <= CAP_SHUT;
      have_first <= 1'b0;
    end else if (take) begin
      have_first <= 1'b1;
      first_byte <= beat_data;
    end
  end

  AST_CLOSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    final_beat |=> !beat_ready); // R10
  AST_OPEN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (beat_ready && !have_first)); // R9
endmodule

// File: rtl/af_match_core.sv
module af_match_core
  import af_pkg::*;
(
  input  filt_cfg_t cfg,
  input  byte_t     first_byte,
  input  byte_t     last_byte,
  output logic      accept
);
  logic [NUM_ADDR-1:0]  eq_first;
  logic [NUM_ADDR-1:0]  eq_last;
  logic [NUM_PAIRS-1:0] pair_hit;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
    byte_t care;
    if (i < NUM_MASKED) begin : g_masked
      assign care = ~cfg.mask[i];
    end else begin : g_exact
      assign care = '1;
    end
    assign eq_first[i] = ((first_byte ^ cfg.addr[i]) & care) == '0;
    assign eq_last[i]  = ((last_byte  ^ cfg.addr[i]) & care) == '0;
  end

  // Low register of a pair checks the first byte, high register the second
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_hit[p] = eq_first[2*p] && eq_last[2*p+1];
  end

  assign accept = cfg.wide ? (|pair_hit) : (|eq_last);
endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import af_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             addr_valid,
  input  logic [7:0]       addr_data,
  output logic             addr_ready,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic             match,
  output logic             reject
);
  filt_cfg_t frame_cfg;
  logic      final_beat;
  byte_t     first_byte;
  logic      accept;

  af_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .frame_start(frame_start), .frame_cfg(frame_cfg)
  );

  af_capture u_cap (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wide(frame_cfg.wide),
    .beat_valid(addr_valid), .beat_data(addr_data), .beat_ready(addr_ready),
    .final_beat(final_beat), .first_byte(first_byte)
  );

  af_match_core u_core (
    .cfg(frame_cfg), .first_byte(first_byte), .last_byte(addr_data),
    .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match  <= 1'b0;
      reject <= 1'b0;
    end else begin
      match  <= final_beat && accept;
      reject <= final_beat && !accept;
    end
  end

  AST_SINGLE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(match && reject)); // R7
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match); // R7
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject); // R7
  AST_VERDICT_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (match || reject) |-> $past(addr_valid && addr_ready && !frame_start)); // R7
  AST_NO_VERDICT_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> !(match || reject)); // R9
endmodule

// File: tb/tb_addr_filter.sv
module tb_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start, addr_valid, cfg_we;
  logic [7:0] addr_data, cfg_wdata;
  logic [2:0] cfg_sel;
  logic       addr_ready, match, reject;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk; // 50 MHz

  addr_filter dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .addr_valid(addr_valid),
    .addr_data(addr_data), .addr_ready(addr_ready), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .match(match), .reject(reject)
  );

  // {mode, a0, a1, a2, a3, m0, m1, b0, b1, expect_match}
  localparam int NV = 12;
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 8'h10, 8'h20, 8'h30, 8'h40, 8'h00, 8'h00, 8'h30, 8'h00, 1'b1}, // R2 reg2
    {1'b0, 8'h10, 8'h20, 8'h30, 8'h40, 8'h00, 8'h00, 8'h40, 8'h00, 1'b1}, // R2 reg3
    {1'b0, 8'h10, 8'h20, 8'h30, 8'h40, 8'h00, 8'h00, 8'h55, 8'h00, 1'b0}, // R2 none
    {1'b0, 8'hA0, 8'h20, 8'h30, 8'h40, 8'h0F, 8'h00, 8'hA7, 8'h00, 1'b1}, // R3 mask0
    {1'b0, 8'h11, 8'h22, 8'hC0, 8'h33, 8'h0F, 8'h0F, 8'hC5, 8'h00, 1'b0}, // R4 reg2 exact
    {1'b0, 8'h11, 8'h22, 8'hC0, 8'h33, 8'h00, 8'hF0, 8'hF2, 8'h00, 1'b1}, // R3 mask1
    {1'b1, 8'h34, 8'h12, 8'h78, 8'h56, 8'h00, 8'h00, 8'h34, 8'h12, 1'b1}, // R5 pair0
    {1'b1, 8'h34, 8'h12, 8'h78, 8'h56, 8'h00, 8'h00, 8'h78, 8'h56, 1'b1}, // R5 pair1
    {1'b1, 8'h34, 8'h12, 8'h78, 8'h56, 8'h00, 8'h00, 8'h34, 8'h56, 1'b0}, // R5 cross
    {1'b1, 8'h34, 8'h12, 8'h78, 8'h56, 8'h00, 8'h00, 8'h12, 8'h34, 1'b0}, // R5 order
    {1'b1, 8'h34, 8'h12, 8'h78, 8'h56, 8'hFF, 8'h00, 8'h99, 8'h12, 1'b1}, // R6 mask
    {1'b1, 8'h34, 8'h12, 8'h78, 8'h56, 8'hFF, 8'h00, 8'h79, 8'h56, 1'b0}  // R6/R4
  };

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic load_cfg(input logic md, input logic [7:0] a0, a1, a2, a3, m0, m1);
    write_reg(3'd0, a0); write_reg(3'd1, a1); write_reg(3'd2, a2);
    write_reg(3'd3, a3); write_reg(3'd4, m0); write_reg(3'd5, m1);
    write_reg(3'd6, {7'd0, md});
  endtask

  task automatic start_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); addr_valid = 1'b1; addr_data = b;
    @(negedge clk); addr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; addr_valid = 1'b0; addr_data = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 match", match, 1'b0);
    check("R1 reject", reject, 1'b0);
    check("R1 ready", addr_ready, 1'b0);
    rst_n = 1'b1;

    // R10: bytes before any frame start are ignored
    load_cfg(1'b0, 8'h10, 8'h20, 8'h30, 8'h40, 8'h00, 8'h00);
    check("R10 ready idle", addr_ready, 1'b0);
    send(8'h10);
    check("R10 no verdict idle", match | reject, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [65:0] v;
      v = VEC[k];
      load_cfg(v[65], v[64:57], v[56:49], v[48:41], v[40:33], v[32:25], v[24:17]);
      start_frame();
      if (v[65]) begin
        send(v[16:9]);
        check("R7 no early verdict", match | reject, 1'b0);
        send(v[8:1]);
      end else begin
        send(v[16:9]);
      end
      check(v[65] ? "R5/R6 match" : "R2/R3/R4 match", match, v[0]);
      check("R7 reject", reject, ~v[0]);
      @(negedge clk);
      check("R7 one-cycle pulse", match | reject, 1'b0);
    end

    // R9: abort after one byte in two-byte mode
    load_cfg(1'b1, 8'h34, 8'h12, 8'h78, 8'h56, 8'h00, 8'h00);
    start_frame();
    send(8'h34);
    start_frame();
    check("R9 no verdict on abort", match | reject, 1'b0);
    check("R9 ready reopened", addr_ready, 1'b1);
    send(8'h78);
    check("R9 first byte restarts", match | reject, 1'b0);
    send(8'h56);
    check("R9 fresh frame match", match, 1'b1);

    // R9: byte in same cycle as frame start is dropped
    load_cfg(1'b0, 8'h10, 8'h20, 8'h30, 8'h40, 8'h00, 8'h00);
    @(negedge clk); frame_start = 1'b1; addr_valid = 1'b1; addr_data = 8'h10;
    @(negedge clk); frame_start = 1'b0; addr_valid = 1'b0;
    check("R9 concurrent byte dropped", match | reject, 1'b0);
    check("R9 ready after start", addr_ready, 1'b1);
    send(8'h10);
    check("R9 later byte decides", match, 1'b1);

    // R10: ready low after last byte, extra bytes ignored
    check("R10 ready closed", addr_ready, 1'b0);
    send(8'h10);
    check("R10 closed byte ignored", match | reject, 1'b0);

    // R8: writes during an open frame do not affect it
    start_frame();
    write_reg(3'd0, 8'h77);
    write_reg(3'd6, 8'h01);
    send(8'h10);
    check("R8 old config used", match, 1'b1);
    start_frame();
    send(8'h77);
    check("R8 new mode two-byte", match | reject, 1'b0);
    send(8'h20);
    check("R8 new config used", match, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule